// File: doc/BRIEF.md
# Serial ADC Result Port

This block is the digital half of a 12-bit successive-approximation converter's three-wire serial port. The analog core (sampling, comparator, DAC) is out of scope. A stand-in supplies a parallel conversion result, and this block turns it into the bit stream a receiver would see on the data line. All pins are sampled on a fast system clock. The serial clock and the active-low select are treated as ordinary synchronous inputs, and their edges are detected by comparing each sample with the previous one.

A high-to-low transition of the select starts a frame and captures the result word. Falling serial-clock edges are then counted. The first edge leaves the line undriven. The second edge enables the driver and sends a zero null bit. The next twelve edges send the word MSB first. Further edges send the word again LSB first, starting at B1. After that only zeros are sent. Raising the select at any point ends the frame, releases the line and returns the block to its low-power idle state. The enable output stands in for three-state: when it is low, the data line carries no information and is held at 0.

The result input carries no handshake, so there is no back-pressure. It is sampled once, in the clock cycle in which the select is seen falling. The receiver paces the transfer entirely through the serial clock and can stop it at any time by raising the select.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted (asynchronous, active low), `sdo_oe_o` is 0, `sdo_o` is 0 and `idle_o` is 1.
- R2: The word sent during a frame is the value of `result_i` in the cycle in which `cs_ni` is first seen low. Later changes of `result_i` within the frame have no effect on `sdo_o`.
- R3: After the first falling serial-clock edge of a frame, `sdo_oe_o` is still 0.
- R4: After the second falling edge, `sdo_oe_o` is 1 and `sdo_o` is 0 (the null bit).
- R5: Falling edges 3 through 14 put result bits 11 down to 0 on `sdo_o` in that order, MSB first.
- R6: Falling edges 15 through 25 put result bits 1 up to 11 on `sdo_o` in that order. Bit 0 is not repeated.
- R7: From falling edge 26 onward, `sdo_o` is 0 with `sdo_oe_o` at 1, for as long as edges continue.
- R8: Raising `cs_ni` at any edge count, including before all 12 bits are out, brings `sdo_oe_o` and `sdo_o` to 0 and `idle_o` to 1 one clock later.
- R9: A rising serial-clock edge leaves `sdo_o` and `sdo_oe_o` unchanged.
- R10: Falling serial-clock edges while `cs_ni` is high keep the driver off and do not count toward the next frame.
- R11: `idle_o` is 0 from one clock after `cs_ni` falls until the frame ends.
- R12: Outputs settle one system clock after a falling serial-clock edge is first seen on `sclk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples every input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Active-low select; high means shut down and idle |
| sclk_i | input | 1 | Serial data clock from the receiver |
| result_i | input | W (12) | Straight-binary conversion result, 0 to 4095 |
| sdo_o | output | 1 | Serial data bit, 0 while the driver is off |
| sdo_oe_o | output | 1 | Driver enable; 0 stands for high impedance |
| idle_o | output | 1 | Power-down/idle status, 1 while deselected |

## Verification
The bench builds the block with its default 12-bit word and a two-edge lead-in. The full edge range therefore fits in a 32-edge frame: the hidden first edge, the null bit, both word orders and the zero tail. Random frame lengths from 0 to 32 edges cover every point at which short cycling can cut a frame. Directed all-ones, all-zeros and mixed words make bit-order errors in either direction visible.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [2:0] {
    PH_QUIET = 3'd0,
    PH_NULL  = 3'd1,
    PH_MSB   = 3'd2,
    PH_LSB   = 3'd3,
    PH_TAIL  = 3'd4
  } sp_phase_e;

endpackage

// File: rtl/sp_edge_track.sv
module sp_edge_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic start_o,
  output logic fall_o,
  output logic sel_q_o
);

  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
    end
  end

  assign start_o = cs_q & ~cs_ni;
  assign fall_o  = sclk_q & ~sclk_i;
  assign sel_q_o = cs_q;

endmodule

// File: rtl/sp_frame_ctr.sv
module sp_frame_ctr
  import adc_sp_pkg::*;
#(
  parameter int W    = 12,
  parameter int LEAD = 2,
  localparam int LAST  = LEAD + 2 * W,
  localparam int CNT_W = $clog2(LAST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             start_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output sp_phase_e        phase_o
);

  localparam logic [CNT_W-1:0] C_NULL    = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] C_MSB_END = CNT_W'(LEAD + W);
  localparam logic [CNT_W-1:0] C_LSB_END = CNT_W'(LEAD + 2 * W - 1);
  localparam logic [CNT_W-1:0] C_SAT     = CNT_W'(LAST);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cs_ni || start_i) begin
      cnt_q <= '0;
    end else if (fall_i && (cnt_q != C_SAT)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    if (cnt_q < C_NULL)          phase_o = PH_QUIET;
    else if (cnt_q == C_NULL)    phase_o = PH_NULL;
    else if (cnt_q <= C_MSB_END) phase_o = PH_MSB;
    else if (cnt_q <= C_LSB_END) phase_o = PH_LSB;
    else                         phase_o = PH_TAIL;
  end

  assign cnt_o = cnt_q;

  AST_ONE_EDGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !start_i && !fall_i) |=> $stable(cnt_q)) else $error("count moved without edge"); // R9

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !start_i && fall_i && cnt_q != C_SAT) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("count skipped"); // R12

endmodule

// File: rtl/sp_shift_mux.sv
module sp_shift_mux
  import adc_sp_pkg::*;
#(
  parameter int W    = 12,
  parameter int LEAD = 2,
  localparam int LAST  = LEAD + 2 * W,
  localparam int CNT_W = $clog2(LAST + 1),
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     result_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  sp_phase_e        phase_i,
  output logic             sdo_o,
  output logic             oe_o
);

  logic [W-1:0]     word_q;
  logic [IDX_W-1:0] idx;
  int               n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (start_i) word_q <= result_i;
  end

  always_comb begin
    n   = int'(cnt_i);
    idx = '0;
    if (phase_i == PH_MSB)      idx = IDX_W'(LEAD + W - n);
    else if (phase_i == PH_LSB) idx = IDX_W'(n - LEAD - W);
  end

  assign oe_o  = (phase_i != PH_QUIET);
  assign sdo_o = ((phase_i == PH_MSB) || (phase_i == PH_LSB)) ? word_q[idx] : 1'b0;

  AST_NULL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_NULL) |-> (oe_o && !sdo_o)) else $error("null bit not low"); // R4

  AST_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TAIL) |-> (oe_o && !sdo_o)) else $error("tail not zero"); // R7

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int W    = 12,
  parameter int LEAD = 2,
  localparam int LAST  = LEAD + 2 * W,
  localparam int CNT_W = $clog2(LAST + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         sclk_i,
  input  logic [W-1:0] result_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         idle_o
);

  logic             start;
  logic             fall;
  logic             sel_q;
  logic [CNT_W-1:0] cnt;
  sp_phase_e        phase;

  sp_edge_track i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sclk_i  (sclk_i),
    .start_o (start),
    .fall_o  (fall),
    .sel_q_o (sel_q)
  );

  sp_frame_ctr #(.W(W), .LEAD(LEAD)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .start_i (start),
    .fall_i  (fall),
    .cnt_o   (cnt),
    .phase_o (phase)
  );

  sp_shift_mux #(.W(W), .LEAD(LEAD)) i_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .result_i (result_i),
    .cnt_i    (cnt),
    .phase_i  (phase),
    .sdo_o    (sdo_o),
    .oe_o     (sdo_oe_o)
  );

  assign idle_o = sel_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!sdo_oe_o && !sdo_o)) else $error("driving while idle"); // R8

  AST_DRIVE_ON_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> (cnt == CNT_W'(LEAD))) else $error("enable at wrong edge"); // R3

  AST_DESELECT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!sdo_oe_o && idle_o)) else $error("no release after deselect"); // R8

endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int W    = 12;
  localparam int LEAD = 2;
  localparam int H    = 3;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n  = 1'b1;
  logic         sclk  = 1'b1;
  logic [W-1:0] res   = '0;
  logic         sdo, oe, idle;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #5 clk = ~clk;

  adc_serial_port #(.W(W), .LEAD(LEAD)) i_adc_serial_port (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .sclk_i   (sclk),
    .result_i (res),
    .sdo_o    (sdo),
    .sdo_oe_o (oe),
    .idle_o   (idle)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {oe, sdo} after n falling edges of a frame carrying w
  function automatic logic [1:0] exp_pin(input logic [W-1:0] w, input int n);
    if (n < LEAD)                 return 2'b00;
    if (n == LEAD)                return 2'b10;
    if (n <= LEAD + W)            return {1'b1, w[LEAD + W - n]};
    if (n <= LEAD + 2 * W - 1)    return {1'b1, w[n - LEAD - W]};
    return 2'b10;
  endfunction

  function automatic string tag_for(input int n);
    if (n < LEAD)              return "R3";
    if (n == LEAD)             return "R4";
    if (n <= LEAD + W)         return "R5";
    if (n <= LEAD + 2 * W - 1) return "R6";
    return "R7";
  endfunction

  task automatic half(input logic v);
    @(negedge clk) sclk = v;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic frame(input logic [W-1:0] w, input int edges, input bit disturb);
    logic [1:0] e;
    string      t;
    @(negedge clk) res = w;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    check("R11 idle low in frame", {31'd0, idle}, 32'd0);
    check("R3 quiet before edges", {31'd0, oe}, 32'd0);
    if (disturb) res = ~w;
    for (int n = 1; n <= edges; n++) begin
      half(1'b0);
      e = exp_pin(w, n);
      t = disturb ? {tag_for(n), " R2 R12"} : {tag_for(n), " R12"};
      check(t, {30'd0, oe, sdo}, {30'd0, e});
      half(1'b1);
      check("R9 rise holds", {30'd0, oe, sdo}, {30'd0, e});
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check("R8 release oe", {31'd0, oe}, 32'd0);
    check("R8 idle high", {31'd0, idle}, 32'd1);
    check("R8 sdo low", {31'd0, sdo}, 32'd0);
  endtask

  task automatic idle_clocks(input int k);
    for (int i = 0; i < k; i++) begin
      half(1'b0);
      check("R10 no drive deselected", {30'd0, oe, sdo}, 32'd0);
      half(1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    check("R1 reset oe", {31'd0, oe}, 32'd0);
    check("R1 reset sdo", {31'd0, sdo}, 32'd0);
    check("R1 reset idle", {31'd0, idle}, 32'd1);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    frame(12'hA5C, 32, 1'b1);
    frame(12'hFFF, 27, 1'b0);
    frame(12'h000, 27, 1'b1);
    frame(12'h801, 5, 1'b1);
    idle_clocks(4);
    frame(12'h3C7, 16, 1'b0);
    frame(12'h001, 1, 1'b0);
    frame(12'hFFE, 0, 1'b0);

    // asynchronous reset in the middle of a frame
    @(negedge clk) res = 12'h6B2;
    @(negedge clk) cs_n = 1'b0;
    for (int n = 0; n < 8; n++) begin
      half(1'b0);
      half(1'b1);
    end
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 reset mid-frame oe", {31'd0, oe}, 32'd0);
    check("R1 reset mid-frame idle", {31'd0, idle}, 32'd1);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    frame(12'h6B2, 20, 1'b0);

    for (int k = 0; k < 48; k++) begin
      logic [W-1:0] w;
      int           ed;
      bit           d;
      w  = W'($urandom);
      ed = int'($urandom_range(0, 32));
      d  = 1'($urandom);
      if ($urandom_range(0, 3) == 0) idle_clocks(int'($urandom_range(1, 3)));
      frame(w, ed, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule